// File: doc/BRIEF.md
# IPv4 Header Validate and Hop Update Stage

This stage sits in a forwarding datapath and sees each IPv4 packet as a stream of 32-bit big-endian words. Each word carries a start marker and an end marker, and moves under valid/ready flow control. The stage checks the fixed header fields as they pass. It lowers the time-to-live value in the third word by one and corrects the header checksum in the same word, without summing the header again. The verdict comes out on the end-marker beat of the output stream: `out_drop` means the packet must be discarded, and `out_frag` means it is a fragment.

Every word leaves one cycle after it is accepted, through a single registered slice. Option words and payload words pass through unchanged. A stalled consumer stalls the producer, and no word is lost or repeated. The largest total length allowed for a do-not-fragment packet comes from the `cfg_mtu` input.

Top module: `ipv4_ttl_stage`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: Every accepted input word appears exactly once on the output, in order, one cycle after acceptance. While `out_valid` is 1 and `out_ready` is 0, the output beat holds stable and `in_ready` is 0. Header words 0 and 1 leave unchanged.
- R3: A packet whose version field (word 0 bits 31:28) is not 4 is dropped.
- R4: A packet is dropped if its header-length field (word 0 bits 27:24, in 32-bit words) is below 5. It is also dropped if its end marker arrives before that many words have been seen.
- R5: A packet whose total-length field (word 0 bits 15:0, in bytes) is below 20 is dropped.
- R6: A packet with the reserved flag (word 1 bit 15) set is dropped.
- R7: A packet with the do-not-fragment flag (word 1 bit 14) set and a total length above `cfg_mtu` is dropped. A total length equal to `cfg_mtu`, or a large length with the flag clear, is not a reason to drop.
- R8: A packet whose TTL (word 2 bits 31:24) is 0 or 1 is dropped, and its word 2 leaves unchanged.
- R9: When version is 4, header length is at least 5 and TTL is above 1, word 2 leaves with TTL reduced by one and the checksum (bits 15:0) replaced. The new checksum is the one's-complement value that makes the modified header sum correctly.
- R10: A packet with the more-fragments flag (word 1 bit 13) set, or a nonzero fragment offset (word 1 bits 12:0), has `out_frag` = 1 on its end beat. Being a fragment is not by itself a reason to drop.
- R11: Option and payload words (index 3 onward) leave unchanged. `out_drop` and `out_frag` are 0 on every beat that is not an end beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mtu | input | 16 | Largest total length allowed for do-not-fragment packets |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept a word |
| in_data | input | 32 | Input word, big-endian |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Output word, with word 2 rewritten |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_drop | output | 1 | On the end beat: discard the packet |
| out_frag | output | 1 | On the end beat: the packet is a fragment |

## Verification
The bench rebuilds each expected checksum by summing the whole modified header, so an incremental patch with a carry or complement slip shows up as a wrong word 2. Directed cases hit the edges of each rule: TTL at 0, 1 and 2, total length exactly at the MTU, a long do-not-fragment packet against a long packet without the flag, and headers that end one word early. A design with an off-by-one in any of these comparisons drops a good packet or forwards a bad one. Long runs with `out_ready` held low most of the time check the rule against losing or duplicating words under backpressure. A stall handled wrongly shows up as a shifted or repeated beat in the ordered comparison.

// File: rtl/ipv4_stage_pkg.sv
package ipv4_stage_pkg;

  localparam int WORD_W     = 32;
  localparam int IP_VERSION = 4;
  localparam int MIN_IHL    = 5;
  localparam int MIN_TOTLEN = 20;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              sop;
    logic              eop;
    logic              drop;
    logic              frag;
  } beat_t;

  // one's-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // incremental checksum fix: new = ~(~old_ck + ~old_field + new_field)
  function automatic logic [15:0] csum_adjust(input logic [15:0] ck,
                                              input logic [15:0] old_f,
                                              input logic [15:0] new_f);
    return ~oc_add(oc_add(~ck, ~old_f), new_f);
  endfunction

endpackage

// File: rtl/ipv4_word_track.sv
module ipv4_word_track #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             sop,
  input  logic             eop,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q;

  // a start marker forces index zero even if the previous packet was cut short
  assign idx = sop ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (fire) begin
      if (eop)                idx_q <= '0;
      else if (idx != IDX_MAX) idx_q <= idx + 1'b1;
      else                     idx_q <= idx;
    end
  end
endmodule

// File: rtl/ipv4_hdr_rules.sv
module ipv4_hdr_rules
  import ipv4_stage_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_eop,
  input  logic [LEN_W-1:0]  mtu,
  output logic [WORD_W-1:0] out_data,
  output logic              out_drop,
  output logic              out_frag
);
  localparam logic [IDX_W-1:0] W_LEN  = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_FRAG = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_TTL  = IDX_W'(2);

  logic [3:0]       ihl_q;
  logic [LEN_W-1:0] tl_q;
  logic             hdr_ok_q, bad_q, frag_q;

  logic [3:0]  f_ver, f_ihl, eff_ihl;
  logic [15:0] f_tl;
  logic [7:0]  f_ttl, f_proto, ttl_dec;
  logic [15:0] f_ck;
  logic        bad_now, frag_now, trunc, hdr_ok_now;

  always_comb begin
    f_ver   = in_data[31:28];
    f_ihl   = in_data[27:24];
    f_tl    = in_data[15:0];
    f_ttl   = in_data[31:24];
    f_proto = in_data[23:16];
    f_ck    = in_data[15:0];
    ttl_dec = f_ttl - 8'd1;
    eff_ihl = (idx == W_LEN) ? f_ihl : ihl_q;
    hdr_ok_now = (f_ver == 4'(IP_VERSION)) && (f_ihl >= 4'(MIN_IHL));

    bad_now  = 1'b0;
    frag_now = 1'b0;
    out_data = in_data;
    case (idx)
      W_LEN: begin
        bad_now = !hdr_ok_now || (f_tl < 16'(MIN_TOTLEN));
      end
      W_FRAG: begin
        bad_now  = in_data[15] || (in_data[14] && (tl_q > mtu));
        frag_now = in_data[13] || (in_data[12:0] != 13'd0);
      end
      W_TTL: begin
        bad_now = (f_ttl <= 8'd1);
        if (hdr_ok_q && (f_ttl > 8'd1))
          out_data = {ttl_dec, f_proto,
                      csum_adjust(f_ck, {f_ttl, f_proto}, {ttl_dec, f_proto})};
      end
      default: ;
    endcase

    trunc    = (eff_ihl >= 4'(MIN_IHL)) && (int'(idx) < int'(eff_ihl) - 1);
    out_drop = in_eop && (bad_q || bad_now || trunc);
    out_frag = in_eop && (frag_q || frag_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ihl_q    <= '0;
      tl_q     <= '0;
      hdr_ok_q <= 1'b0;
      bad_q    <= 1'b0;
      frag_q   <= 1'b0;
    end else if (fire) begin
      if (in_eop) begin
        bad_q    <= 1'b0;
        frag_q   <= 1'b0;
        hdr_ok_q <= 1'b0;
      end else if (idx == W_LEN) begin
        ihl_q    <= f_ihl;
        tl_q     <= LEN_W'(f_tl);
        hdr_ok_q <= hdr_ok_now;
        bad_q    <= bad_now;
        frag_q   <= 1'b0;
      end else begin
        bad_q  <= bad_q | bad_now;
        frag_q <= frag_q | frag_now;
      end
    end
  end
endmodule

// File: rtl/ipv4_out_stage.sv
module ipv4_out_stage
  import ipv4_stage_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  beat_t in_beat,
  output logic  in_ready,
  output logic  out_valid,
  output beat_t out_beat,
  input  logic  out_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_beat  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_beat <= in_beat;
    end
  end
endmodule

// File: rtl/ipv4_ttl_stage.sv
module ipv4_ttl_stage
  import ipv4_stage_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_mtu,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_drop,
  output logic              out_frag
);
  logic             fire;
  logic [IDX_W-1:0] idx;
  beat_t            nxt_beat, reg_beat;

  assign fire = in_valid && in_ready;

  ipv4_word_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst(rst), .fire(fire), .sop(in_sop), .eop(in_eop), .idx(idx)
  );

  ipv4_hdr_rules #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_rules (
    .clk(clk), .rst(rst), .fire(fire), .idx(idx), .in_data(in_data),
    .in_eop(in_eop), .mtu(cfg_mtu), .out_data(nxt_beat.data),
    .out_drop(nxt_beat.drop), .out_frag(nxt_beat.frag)
  );

  assign nxt_beat.sop = in_sop;
  assign nxt_beat.eop = in_eop;

  ipv4_out_stage u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_beat(nxt_beat),
    .in_ready(in_ready), .out_valid(out_valid), .out_beat(reg_beat),
    .out_ready(out_ready)
  );

  assign out_data = reg_beat.data;
  assign out_sop  = reg_beat.sop;
  assign out_eop  = reg_beat.eop;
  assign out_drop = reg_beat.drop;
  assign out_frag = reg_beat.frag;
endmodule

// File: rtl/ipv4_ttl_stage_chk.sv
module ipv4_ttl_stage_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_eop,
  input logic        out_drop,
  input logic        out_frag
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $fell(rst) |-> !out_valid);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eop)
                                && $stable(out_drop) && $stable(out_frag));

  // R2
  stall_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R2
  accept_next_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R11
  flags_on_end_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eop |-> !out_drop && !out_frag);
endmodule

bind ipv4_ttl_stage ipv4_ttl_stage_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_eop(out_eop), .out_drop(out_drop), .out_frag(out_frag)
);

// File: tb/ipv4_ttl_stage_bench.sv
`timescale 1ns/1ps
module ipv4_ttl_stage_bench;
  localparam int MTU  = 1500;
  localparam int MAXB = 4096;
  localparam int K_GOOD = 0, K_VER = 1, K_IHL = 2, K_TL = 3, K_RSV = 4, K_DFBIG = 5,
                 K_DFEQ = 6, K_NODF = 7, K_TTL = 8, K_TTL2 = 9, K_MF = 10, K_OFF = 11,
                 K_OPT = 12, K_TRUNC = 13, K_TTLMAX = 14, NK = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_mtu = 16'(MTU);
  logic        in_valid = 1'b0, in_ready, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid, out_ready = 1'b0, out_sop, out_eop, out_drop, out_frag;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  ipv4_ttl_stage u_ipv4_ttl_stage (
    .clk(clk), .rst(rst), .cfg_mtu(cfg_mtu), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_drop(out_drop), .out_frag(out_frag)
  );

  logic [31:0] s_data [MAXB];
  logic        s_sop [MAXB], s_eop [MAXB];
  logic [31:0] e_data [MAXB];
  logic        e_sop [MAXB], e_eop [MAXB], e_drop [MAXB], e_frag [MAXB];
  string       e_tag [MAXB];
  int s_cnt = 0, e_cnt = 0;
  int checks = 0, failures = 0;

  // full checksum over hw header words, field in word 2 assumed zero
  function automatic logic [15:0] hdr_sum(input logic [31:0] h [15], input int hw);
    int s = 0;
    for (int i = 0; i < hw; i++) s += int'(h[i][31:16]) + int'(h[i][15:0]);
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic add_pkt(input int kind);
    logic [31:0] h [15];
    logic [31:0] x [15];
    int ver = 4, ihl = 5, npay, tl = -1, n, hw, off = 0, ttl;
    bit rsv = 0, df, mf = 0, rewrite, drop, frag;
    string tag = "R9";
    logic [31:0] pw;
    npay = int'($urandom % 4);
    df   = 1'($urandom % 2);
    ttl  = 2 + int'($urandom % 254);
    case (kind)
      K_VER:    begin ver = (4 + 1 + int'($urandom % 15)) % 16; tag = "R3"; end
      K_IHL:    begin ihl = int'($urandom % 5); tl = 20 + 4 * npay; tag = "R4"; end
      K_TL:     begin tl = int'($urandom % 20); tag = "R5"; end
      K_RSV:    begin rsv = 1; tag = "R6"; end
      K_DFBIG:  begin df = 1; tl = MTU + 1 + int'($urandom % 100); tag = "R7"; end
      K_DFEQ:   begin df = 1; tl = MTU; tag = "R7"; end
      K_NODF:   begin df = 0; tl = MTU + 50; tag = "R7"; end
      K_TTL:    begin ttl = int'($urandom % 2); tag = "R8"; end
      K_TTL2:   begin ttl = 2; tag = "R9"; end
      K_TTLMAX: begin ttl = 255; tag = "R9"; end
      K_MF:     begin mf = 1; tag = "R10"; end
      K_OFF:    begin off = 1 + int'($urandom % 8191); tag = "R10"; end
      K_OPT:    begin ihl = 6 + int'($urandom % 10); tag = "R11"; end
      K_TRUNC:  begin ihl = 5 + int'($urandom % 4); npay = 0; tag = "R4"; end
      default: ;
    endcase
    hw = (ihl >= 5) ? ihl : 5;
    if (tl < 0) tl = (hw + npay) * 4;
    n = (kind == K_TRUNC) ? hw - 1 : hw + npay;
    for (int i = 0; i < 15; i++) h[i] = $urandom;
    h[0] = {ver[3:0], ihl[3:0], 8'($urandom), tl[15:0]};
    h[1] = {16'($urandom), rsv, df, mf, off[12:0]};
    h[2] = {ttl[7:0], 8'($urandom), 16'h0};
    h[2][15:0] = hdr_sum(h, hw);
    x = h;
    rewrite = (ver == 4) && (ihl >= 5) && (ttl > 1) && (n >= 3);
    if (rewrite) begin
      x[2][31:24] = 8'(ttl - 1);
      x[2][15:0]  = 16'h0;
      x[2][15:0]  = hdr_sum(x, hw);
    end
    drop = (ver != 4) || (ihl < 5) || (tl < 20)
        || (n >= 2 && rsv) || (n >= 2 && df && tl > MTU)
        || (n >= 3 && ttl <= 1) || (ihl >= 5 && n < ihl);
    frag = (n >= 2) && (mf || off != 0);
    for (int i = 0; i < n; i++) begin
      pw = (i < hw) ? h[i] : $urandom;
      s_data[s_cnt] = pw;
      s_sop[s_cnt]  = (i == 0);
      s_eop[s_cnt]  = (i == n - 1);
      s_cnt++;
      e_data[e_cnt] = (i < hw) ? x[i] : pw;
      e_sop[e_cnt]  = (i == 0);
      e_eop[e_cnt]  = (i == n - 1);
      e_drop[e_cnt] = (i == n - 1) && drop;
      e_frag[e_cnt] = (i == n - 1) && frag;
      if (i == n - 1)  e_tag[e_cnt] = tag;
      else if (i == 2) e_tag[e_cnt] = rewrite ? "R9" : "R8";
      else if (i < 2)  e_tag[e_cnt] = "R2";
      else             e_tag[e_cnt] = "R11";
      e_cnt++;
    end
  endtask

  // drive and collect, vrate/rrate in percent; ordered comparison covers R2
  task automatic run(input int vrate, input int rrate);
    int si = 0, rx = 0, cyc = 0;
    bit held = 0;
    while (rx < e_cnt) begin
      @(negedge clk);
      cyc++;
      if (cyc > 60000) begin
        checks++; failures++;
        $display("FAIL R2 watchdog: received %0d expected %0d", rx, e_cnt);
        break;
      end
      out_ready = (int'($urandom % 100) < rrate);
      if (held)            in_valid = 1'b1;
      else if (si < s_cnt) in_valid = (int'($urandom % 100) < vrate);
      else                 in_valid = 1'b0;
      if (in_valid) begin
        in_data = s_data[si]; in_sop = s_sop[si]; in_eop = s_eop[si];
      end
      #1;
      if (out_valid && out_ready) begin
        checks++;
        if ({out_data, out_sop, out_eop, out_drop, out_frag} !==
            {e_data[rx], e_sop[rx], e_eop[rx], e_drop[rx], e_frag[rx]}) begin
          failures++;
          $display("FAIL %s beat %0d: got data=%h sop=%b eop=%b drop=%b frag=%b exp data=%h sop=%b eop=%b drop=%b frag=%b",
                   e_tag[rx], rx, out_data, out_sop, out_eop, out_drop, out_frag,
                   e_data[rx], e_sop[rx], e_eop[rx], e_drop[rx], e_frag[rx]);
        end
        rx++;
      end
      held = in_valid && !in_ready;
      if (in_valid && in_ready) si++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    s_cnt = 0;
    e_cnt = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 in reset: out_valid=%b in_ready=%b exp 0 1", out_valid, in_ready);
    end
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 after reset: out_valid=%b in_ready=%b exp 0 1", out_valid, in_ready);
    end

    // directed: every kind, free-flowing then heavy backpressure
    for (int k = 0; k < NK; k++) begin add_pkt(k); add_pkt(k); end
    run(100, 100);
    for (int k = 0; k < NK; k++) add_pkt(k);
    run(100, 25);

    // random mixes
    for (int p = 0; p < 250; p++) add_pkt(int'($urandom % NK));
    run(70, 60);
    for (int p = 0; p < 250; p++) add_pkt(int'($urandom % NK));
    run(90, 15);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule